// File: doc/BRIEF.md
# Packed Lane Shifter with Overshift Handling

This block shifts every lane of a 64-bit packed operand by one common count. It offers logical left, logical right and arithmetic right shifts, and the lanes can be 16, 32 or 64 bits wide. The count comes from one of two places: a full 64-bit register value, or an 8-bit immediate that is zero-extended. The block compares the whole count against the lane width. A count of the lane width or more therefore gives a defined answer: zero for the logical shifts, and the lane's sign bit in every position for the arithmetic shift.

The shift logic is combinational. The result and an error flag are registered, so they appear one clock after the inputs are applied. The element-size code for 8-bit lanes is not supported. When that code is given, the block raises the error flag and passes the operand through unchanged.

Top module: `pshift_lanes`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` becomes zero and `size_err` becomes 0.
- R2: `result` and `size_err` reflect the inputs sampled at the previous rising clock edge. A change of input does not reach the outputs before the next edge.
- R3: `esize` selects the lane width: 2'b01 gives 16 bits, 2'b10 gives 32 bits and 2'b11 gives 64 bits. Lane i occupies bits [i*W+W-1 : i*W], and the same count applies to every lane.
- R4: When `kind` is 2'b00 (logical left) and the count is below the lane width, each lane is shifted toward its top. Bits that leave the top of the lane are lost, and the bottom is filled with zeros.
- R5: When `kind` is 2'b01 (logical right) and the count is below the lane width, the vacated upper bits of each lane are zeros. No bit comes from the neighbouring lane.
- R6: When `kind[1]` is 1 (2'b10 or 2'b11, arithmetic right) and the count is below the lane width, the vacated upper bits of each lane repeat that lane's original top bit.
- R7: The count is an unsigned 64-bit value with no bits masked off. Under a logical shift, a count greater than or equal to the lane width makes that lane zero, even when only high-order count bits are set.
- R8: Under an arithmetic shift, a count greater than or equal to the lane width fills the lane with its original top bit.
- R9: When `use_imm` is 1, the count is `cnt_imm` zero-extended to 64 bits, and `cnt_reg` has no effect. When `use_imm` is 0, the count is `cnt_reg`.
- R10: When `esize` is 2'b00 (8-bit lanes, not supported), `size_err` is 1 on the next cycle and `result` equals `opnd_a`. For any other `esize`, `size_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 64 | Packed operand to be shifted |
| cnt_reg | input | 64 | Register shift count, unsigned |
| cnt_imm | input | 8 | Immediate shift count, zero-extended |
| use_imm | input | 1 | 1 selects `cnt_imm`, 0 selects `cnt_reg` |
| kind | input | 2 | 00 logical left, 01 logical right, 1x arithmetic right |
| esize | input | 2 | 00 unsupported, 01 16-bit, 10 32-bit, 11 64-bit lanes |
| result | output | 64 | Registered packed result |
| size_err | output | 1 | Registered flag for the unsupported lane width |

## Verification
Every result and the error flag fall due exactly one rising edge after their inputs are applied. The bench drives a new stimulus on each falling edge and computes its expected value with a behavioural lane model. It compares that value at the following falling edge, once the register has captured it. Just after driving new inputs, and before the edge, the bench also confirms that the outputs still hold the previous expected value. This separates a one-cycle latency from a combinational or doubly registered path.

// File: rtl/pshift_pkg.sv
package pshift_pkg;
  typedef enum logic [1:0] {
    SH_LSL  = 2'b00,
    SH_LSR  = 2'b01,
    SH_ASR  = 2'b10,
    SH_ASR2 = 2'b11
  } shift_kind_e;

  localparam int unsigned MIN_LOG_LANE = 4;
  localparam int unsigned MAX_LOG_LANE = 6;
  localparam logic [1:0]  ESIZE_BAD    = 2'b00;
endpackage

// File: rtl/pshift_lane.sv
module pshift_lane #(
  parameter int unsigned LW = 16,
  localparam int unsigned AW = $clog2(LW)
) (
  input  logic [LW-1:0] din,
  input  logic [AW-1:0] amt,
  input  logic          over,
  input  logic [1:0]    kind,
  output logic [LW-1:0] dout
);
  logic sgn;
  assign sgn = din[LW-1];

  always_comb begin
    if (kind[1]) begin
      if (over) dout = {LW{sgn}};
      else      dout = $signed(din) >>> amt;
    end else if (kind[0]) begin
      if (over) dout = '0;
      else      dout = din >> amt;
    end else begin
      if (over) dout = '0;
      else      dout = din << amt;
    end
  end
endmodule

// File: rtl/pshift_slice.sv
module pshift_slice #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned LW     = 16,
  localparam int unsigned AW    = $clog2(LW),
  localparam int unsigned LANES = DATA_W / LW
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [1:0]        kind,
  output logic [DATA_W-1:0] res
);
  logic          over;
  logic [AW-1:0] amt;

  assign over = |cnt[CNT_W-1:AW];
  assign amt  = cnt[AW-1:0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pshift_lane #(.LW(LW)) u_lane (
      .din  (data[i*LW +: LW]),
      .amt  (amt),
      .over (over),
      .kind (kind),
      .dout (res[i*LW +: LW])
    );
  end
endmodule

// File: rtl/pshift_lanes.sv
module pshift_lanes #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [CNT_W-1:0]  cnt_reg,
  input  logic [IMM_W-1:0]  cnt_imm,
  input  logic              use_imm,
  input  logic [1:0]        kind,
  input  logic [1:0]        esize,
  output logic [DATA_W-1:0] result,
  output logic              size_err
);
  import pshift_pkg::*;

  localparam int unsigned NSIZE = MAX_LOG_LANE - MIN_LOG_LANE + 1;

  logic [CNT_W-1:0]  eff_cnt;
  logic [DATA_W-1:0] by_size [NSIZE];
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_err;

  assign eff_cnt = use_imm ? CNT_W'(cnt_imm) : cnt_reg;

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    pshift_slice #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .LW     (1 << (MIN_LOG_LANE + s))
    ) u_slice (
      .data (opnd_a),
      .cnt  (eff_cnt),
      .kind (kind),
      .res  (by_size[s])
    );
  end

  always_comb begin
    nxt_err = 1'b0;
    case (esize)
      2'b01:   nxt_res = by_size[0];
      2'b10:   nxt_res = by_size[1];
      2'b11:   nxt_res = by_size[2];
      default: begin
        nxt_res = opnd_a;
        nxt_err = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      size_err <= 1'b0;
    end else begin
      result   <= nxt_res;
      size_err <= nxt_err;
    end
  end
endmodule

// File: rtl/pshift_lanes_chk.sv
module pshift_lanes_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned IMM_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] opnd_a,
  input logic [CNT_W-1:0]  cnt_reg,
  input logic [IMM_W-1:0]  cnt_imm,
  input logic              use_imm,
  input logic [1:0]        kind,
  input logic [1:0]        esize,
  input logic [DATA_W-1:0] result,
  input logic              size_err
);
  logic [CNT_W-1:0] cnt_c;
  assign cnt_c = use_imm ? CNT_W'(cnt_imm) : cnt_reg;

  // R10
  bad_size_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (esize == 2'b00) |=> (size_err && result == $past(opnd_a)));

  // R10
  good_size_noerr_chk: assert property (@(posedge clk) disable iff (rst)
    (esize != 2'b00) |=> !size_err);

  // R7
  lsl_over_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (esize == 2'b01 && kind == 2'b00 && cnt_c >= CNT_W'(16)) |=> (result == '0));

  // R8
  asr_over_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (esize == 2'b11 && kind[1] && cnt_c >= CNT_W'(64))
    |=> (result == {DATA_W{$past(opnd_a[DATA_W-1])}}));

  // R9
  imm_zero_ident_chk: assert property (@(posedge clk) disable iff (rst)
    (use_imm && cnt_imm == '0 && esize != 2'b00) |=> (result == $past(opnd_a)));

  // R5
  lsr_top_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (esize == 2'b01 && kind == 2'b01 && cnt_c != '0 && cnt_c < CNT_W'(16))
    |=> (!result[15] && !result[31] && !result[47] && !result[63]));
endmodule

bind pshift_lanes pshift_lanes_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W),
  .IMM_W  (IMM_W)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .opnd_a   (opnd_a),
  .cnt_reg  (cnt_reg),
  .cnt_imm  (cnt_imm),
  .use_imm  (use_imm),
  .kind     (kind),
  .esize    (esize),
  .result   (result),
  .size_err (size_err)
);

// File: tb/test_pshift_lanes.sv
module test_pshift_lanes;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] opnd_a = '0;
  logic [63:0] cnt_reg = '0;
  logic [7:0]  cnt_imm = '0;
  logic        use_imm = 1'b0;
  logic [1:0]  kind = '0;
  logic [1:0]  esize = 2'b01;
  logic [63:0] result;
  logic        size_err;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] prev_exp = '0;
  logic        prev_err = 1'b0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #(PERIOD/2) clk = ~clk;

  pshift_lanes i_pshift_lanes (
    .clk(clk), .rst(rst), .opnd_a(opnd_a), .cnt_reg(cnt_reg),
    .cnt_imm(cnt_imm), .use_imm(use_imm), .kind(kind), .esize(esize),
    .result(result), .size_err(size_err)
  );

  function automatic logic [63:0] model(input logic [63:0] a, cr,
      input logic [7:0] im, input logic ui, input logic [1:0] k, es);
    logic [63:0] c, m, v, sv, o, res;
    int lw, n, sh;
    c = ui ? {56'd0, im} : cr;
    if (es == 2'b00) return a;
    lw = 8 << es;
    n = 64 / lw;
    m = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
    res = '0;
    for (int i = 0; i < n; i++) begin
      v = (a >> (i * lw)) & m;
      if (c >= 64'(lw)) begin
        o = (k[1] && v[lw-1]) ? m : 64'd0;
      end else begin
        sh = int'(c);
        if (k[1]) begin
          sv = v[lw-1] ? (v | ~m) : v;
          o = 64'($signed(sv) >>> sh) & m;
        end else if (k[0]) begin
          o = v >> sh;
        end else begin
          o = (v << sh) & m;
        end
      end
      res = res | (o << (i * lw));
    end
    return res;
  endfunction

  task automatic check(input logic [63:0] act, exp, input logic ae, ee,
                       input string tag);
    n_cmp++;
    if (act !== exp || ae !== ee) begin
      n_bad++;
      $display("FAIL %s: result=%h err=%b expected result=%h err=%b",
               tag, act, ae, exp, ee);
    end
  endtask

  task automatic step(input logic [63:0] a, cr, input logic [7:0] im,
                      input logic ui, input logic [1:0] k, es,
                      input string tag);
    logic [63:0] e;
    opnd_a = a; cnt_reg = cr; cnt_imm = im; use_imm = ui; kind = k; esize = es;
    #1;
    check(result, prev_exp, size_err, prev_err, "R2 output holds until edge");
    e = model(a, cr, im, ui, k, es);
    @(posedge clk);
    @(negedge clk);
    check(result, e, size_err, (es == 2'b00), tag);
    prev_exp = e;
    prev_err = (es == 2'b00);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    opnd_a = 64'hFFFF_FFFF_FFFF_FFFF;
    esize = 2'b00;
    repeat (3) @(negedge clk);
    check(result, 64'd0, size_err, 1'b0, "R1 reset state");
    rst = 1'b0;

    // R9 zero immediate, R3 lanes
    step(64'h0123_4567_89AB_CDEF, 64'd5, 8'd0, 1'b1, 2'b00, 2'b01, "R9 imm zero count");
    // R4 left shifts
    step(64'h8001_4002_C003_F00F, 64'd4, 8'd0, 1'b0, 2'b00, 2'b01, "R4 lsl16 by 4");
    step(64'h8765_4321_FEDC_BA98, 64'd7, 8'd0, 1'b0, 2'b00, 2'b10, "R4 lsl32 by 7");
    step(64'hF123_4567_89AB_CDEF, 64'd13, 8'd0, 1'b0, 2'b00, 2'b11, "R4 lsl64 by 13");
    // R5 logical right, no neighbour bits
    step(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 8'd0, 1'b0, 2'b01, 2'b01, "R5 lsr16 by 3");
    step(64'hFFFF_FFFF_0000_0001, 64'd31, 8'd0, 1'b0, 2'b01, 2'b10, "R5 lsr32 by 31");
    // R6 arithmetic right
    step(64'h8000_0010_7FFF_FFF0, 64'd5, 8'd0, 1'b0, 2'b10, 2'b10, "R6 asr32 by 5");
    step(64'h8000_7FFF_F0F0_0F0F, 64'd15, 8'd0, 1'b0, 2'b11, 2'b01, "R6 asr16 code 11 by 15");
    // R7 overshift logical
    step(64'h1234_5678_9ABC_DEF0, 64'd16, 8'd0, 1'b0, 2'b00, 2'b01, "R7 lsl16 count 16");
    step(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0100_0000_0001, 8'd0, 1'b0, 2'b01, 2'b10, "R7 lsr32 high count bit");
    step(64'hDEAD_BEEF_CAFE_F00D, 64'd64, 8'd0, 1'b0, 2'b00, 2'b11, "R7 lsl64 count 64");
    // R8 overshift arithmetic
    step(64'h8000_0000_7FFF_FFFF, 64'd32, 8'd0, 1'b0, 2'b10, 2'b10, "R8 asr32 count 32");
    step(64'h8123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd0, 1'b0, 2'b10, 2'b11, "R8 asr64 all ones count");
    // R9 immediate select, register count ignored
    step(64'h00FF_00FF_00FF_00FF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd8, 1'b1, 2'b00, 2'b01, "R9 imm 8 overrides reg");
    step(64'h8000_0000_0000_0000, 64'd1, 8'd255, 1'b1, 2'b11, 2'b11, "R9 imm 255 asr64");
    step(64'h0F0F_0F0F_0F0F_0F0F, 64'd0, 8'd200, 1'b0, 2'b01, 2'b11, "R9 reg count 0 used");
    // R10 unsupported width
    step(64'hA5A5_5A5A_1234_8765, 64'd3, 8'd0, 1'b0, 2'b00, 2'b00, "R10 esize 00 passthrough");
    step(64'h0000_0000_0000_0001, 64'd1, 8'd0, 1'b0, 2'b00, 2'b01, "R10 error clears");

    // R3 mixed patterns over all widths and kinds
    for (int t = 0; t < 300; t++) begin
      logic [63:0] a, c;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      a = lfsr ^ (lfsr << 17);
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      c = (t % 5 == 0) ? lfsr : {57'd0, lfsr[6:0]};
      step(a, c, lfsr[15:8], lfsr[20], lfsr[33:32], lfsr[41:40], "R3 mixed lanes");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule